// File: doc/BRIEF.md
# Prioritized Nesting Interrupt Controller

This block sits beside a program sequencer and decides which interrupt the sequencer should take next. It gathers requests from three external pins and from five internal event lines (an interval timer plus a transmit and a receive line for each of two serial ports). It filters them through a mask register and offers the highest-priority survivor together with its vector address. The sequencer answers with an acknowledge strobe when it branches to the vector, and with a return strobe when the handler finishes.

On acknowledge, the controller saves the arithmetic status word, the mode status word and the current mask on a small internal stack. On return, it restores the mask and hands the two saved status words back to the sequencer. A control register selects edge or level detection for each external pin. The same register chooses between nested service, where a more urgent request may interrupt a running handler, and sequential service, where one handler runs at a time. A write-only force/clear register lets software raise or withdraw any latched request.

Top module: `irq_ctrl_top`

## Requirements
- R1: While and after reset, no interrupt is offered, the mask is all zeros so every source is masked, the stack is empty and the overflow flag is clear.
- R2: A pending source whose mask bit is 0 is never offered. Setting its bit in the mask register (write address 0, bit i for source i) lets it be offered.
- R3: Source i has priority i, and 0 is the most urgent. The sources are: 0 external pin 2; 1 port-0 transmit; 2 port-0 receive; 3 port-1 transmit or external pin 1; 4 port-1 receive or external pin 0; 5 timer. The lowest-numbered eligible source is offered, with vector 4 + 4*i. Internal event pulses are always latched.
- R4: With a pin's edge bit set (control register, write address 1, bit p for external pin p), a rising edge is latched. The request stays offered after the pin falls, and it is cleared only when that interrupt is acknowledged.
- R5: With a pin's edge bit clear, the request is not latched and follows the pin. Dropping the pin withdraws the offer.
- R6: With control bit 4 set (nested), a source is eligible only if it is more urgent than every handler in service. A less urgent or equal request waits, and a more urgent one is offered.
- R7: With control bit 4 clear (sequential), nothing is offered while any handler is in service.
- R8: A write to address 2 sets the latch of source i when bit i is 1 and clears it when bit 8+i is 1. When both bits are set for the same source, the clear wins.
- R9: An acknowledge of an offered interrupt pushes {arithmetic status, mode status, mask}. A return pops the entry: the mask is restored, the two status words appear on the restore outputs with restore_valid high for one cycle, and stack_level counts the entries.
- R10: An acknowledge with STACK_DEPTH entries already stored leaves the stack and its contents unchanged and sets a sticky overflow flag, which only reset clears.
- R11: An acknowledge while nothing is offered has no effect. A return on an empty stack produces no restore_valid and leaves the level at 0.
- R12: The offer is registered. A level request shows one edge after the pin is sampled. A latched request (edge, force or event) shows two edges after its cause. A mask write takes effect on the offer one edge after it is written. The offer drops in the cycle after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq | input | 3 | External interrupt pins, active high |
| tmr_evt | input | 1 | Timer expiry pulse |
| sp0_tx_evt | input | 1 | Serial port 0 transmit done pulse |
| sp0_rx_evt | input | 1 | Serial port 0 receive done pulse |
| sp1_tx_evt | input | 1 | Serial port 1 transmit done pulse |
| sp1_rx_evt | input | 1 | Serial port 1 receive done pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 mask, 1 control, 2 force/clear |
| wr_data | input | DATA_W | Register write data |
| astat_in | input | ASTAT_W | Arithmetic status to save |
| mstat_in | input | MSTAT_W | Mode status to save |
| ack | input | 1 | Sequencer took the offered interrupt |
| rti | input | 1 | Return from interrupt |
| irq_valid | output | 1 | An interrupt is offered |
| irq_vector | output | ADDR_W | Vector address of the offer |
| irq_src | output | 3 | Source number of the offer |
| mask_out | output | 6 | Current mask register |
| astat_restore | output | ASTAT_W | Restored arithmetic status |
| mstat_restore | output | MSTAT_W | Restored mode status |
| restore_valid | output | 1 | Restore outputs valid this cycle |
| stack_level | output | $clog2(STACK_DEPTH+1) | Entries on the status stack |
| stack_ovf | output | 1 | Sticky stack overflow |

## Verification
Every result has a fixed latency. A level pin reaches the offer one edge after it is sampled. A latched cause (pin edge, event pulse or force write) reaches the offer after two edges. A mask or control write reaches it one edge after the write edge. Acknowledge and return update the stack, the restore outputs and the mask on their own edge. The bench drives inputs just after a rising edge, advances a counted number of edges and samples after each. It also checks the intermediate edge where the old value must still show. The priority encoder is swept over all 64 forced request sets under four masks, and the expected vector is computed arithmetically.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC     = 6;
  localparam int NPIN     = 3;
  localparam int IDW      = $clog2(NSRC);
  localparam int NEST_BIT = 4;
  localparam int CLR_LSB  = 8;

  typedef enum logic [1:0] {
    WA_MASK = 2'd0,
    WA_CTRL = 2'd1,
    WA_FC   = 2'd2
  } wr_addr_e;

  // External pin number to source number (priority position)
  function automatic int pin_src(input int p);
    case (p)
      2:       return 0;
      1:       return 3;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] ext_irq,
  input  logic [NPIN-1:0] edge_sel,
  input  logic [NSRC-1:0] int_evt,
  input  logic [NSRC-1:0] force_set,
  input  logic [NSRC-1:0] force_clr,
  input  logic [NSRC-1:0] ack_clr,
  output logic [NSRC-1:0] pending
);
  logic [NPIN-1:0] prev_q;
  logic [NSRC-1:0] lat_q, lat_d, ext_ev, ext_lvl;

  always_comb begin
    ext_ev  = '0;
    ext_lvl = '0;
    for (int p = 0; p < NPIN; p++) begin
      ext_ev[pin_src(p)]  = ext_ev[pin_src(p)]  | (edge_sel[p] & ext_irq[p] & ~prev_q[p]);
      ext_lvl[pin_src(p)] = ext_lvl[pin_src(p)] | (~edge_sel[p] & ext_irq[p]);
    end
    // new events win over clears in the same cycle; register clear beats force
    lat_d = (lat_q & ~ack_clr & ~force_clr) | (force_set & ~force_clr) | ext_ev | int_evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      lat_q  <= '0;
    end else begin
      prev_q <= ext_irq;
      lat_q  <= lat_d;
    end
  end

  assign pending = lat_q | ext_lvl;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_pkg::*;
(
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] mask,
  input  logic [NSRC-1:0] isr,
  input  logic            nest,
  output logic            hit,
  output logic [IDW-1:0]  idx
);
  logic [NSRC-1:0] allowed, cand;

  for (genvar i = 0; i < NSRC; i++) begin : g_allow
    // nested: nothing at equal or higher urgency in service; sequential: nothing at all
    assign allowed[i] = nest ? ~|isr[i:0] : ~|isr;
  end

  assign cand = pend & mask & allowed;
  assign hit  = |cand;

  always_comb begin
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand[i]) idx = IDW'(i);
    end
  end
endmodule

// File: rtl/irq_stat_stack.sv
module irq_stat_stack #(
  parameter int DEPTH = 7,
  parameter int W     = 22,
  localparam int SPW  = $clog2(DEPTH + 1),
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push,
  input  logic           pop,
  input  logic [W-1:0]   din,
  output logic [W-1:0]   top_data,
  output logic [SPW-1:0] level,
  output logic           ovf
);
  logic [W-1:0]   mem [DEPTH];
  logic [SPW-1:0] sp_q;
  logic           full, empty;

  assign full  = (sp_q == SPW'(DEPTH));
  assign empty = (sp_q == '0);

  always_ff @(posedge clk) begin
    if (push && !full) mem[AW'(sp_q)] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= '0;
      ovf  <= 1'b0;
    end else if (push) begin
      if (full) ovf <= 1'b1;
      else      sp_q <= sp_q + 1'b1;
    end else if (pop && !empty) begin
      sp_q <= sp_q - 1'b1;
    end
  end

  assign top_data = empty ? '0 : mem[AW'(sp_q - 1'b1)];
  assign level    = sp_q;
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 14,
  parameter int ASTAT_W     = 8,
  parameter int MSTAT_W     = 8,
  parameter int STACK_DEPTH = 7,
  parameter int VEC_BASE    = 4,
  parameter int VEC_STEP    = 4,
  localparam int SPW        = $clog2(STACK_DEPTH + 1),
  localparam int ENT_W      = ASTAT_W + MSTAT_W + NSRC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPIN-1:0]    ext_irq,
  input  logic               tmr_evt,
  input  logic               sp0_tx_evt,
  input  logic               sp0_rx_evt,
  input  logic               sp1_tx_evt,
  input  logic               sp1_rx_evt,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ASTAT_W-1:0] astat_in,
  input  logic [MSTAT_W-1:0] mstat_in,
  input  logic               ack,
  input  logic               rti,
  output logic               irq_valid,
  output logic [ADDR_W-1:0]  irq_vector,
  output logic [IDW-1:0]     irq_src,
  output logic [NSRC-1:0]    mask_out,
  output logic [ASTAT_W-1:0] astat_restore,
  output logic [MSTAT_W-1:0] mstat_restore,
  output logic               restore_valid,
  output logic [SPW-1:0]     stack_level,
  output logic               stack_ovf
);
  logic [NSRC-1:0]  mask_q, isr_q, pend, force_set, force_clr, ack_clr, int_evt;
  logic [NPIN-1:0]  edge_q;
  logic             nest_q, sel_hit, ack_eff, pop_ok, wr_fc;
  logic [IDW-1:0]   sel_idx;
  logic [ENT_W-1:0] top_ent;

  assign wr_fc     = wr_en && (wr_addr == WA_FC);
  assign force_set = wr_fc ? wr_data[NSRC-1:0] : '0;
  assign force_clr = wr_fc ? wr_data[CLR_LSB +: NSRC] : '0;
  assign ack_eff   = ack & irq_valid & ~rti;
  assign pop_ok    = rti & (stack_level != '0);
  assign ack_clr   = ack_eff ? (NSRC'(1) << irq_src) : '0;
  assign int_evt   = {tmr_evt, sp1_rx_evt, sp1_tx_evt, sp0_rx_evt, sp0_tx_evt, 1'b0};

  irq_req_capture u_cap (
    .clk(clk), .rst(rst), .ext_irq(ext_irq), .edge_sel(edge_q), .int_evt(int_evt),
    .force_set(force_set), .force_clr(force_clr), .ack_clr(ack_clr), .pending(pend)
  );

  irq_prio_sel u_sel (
    .pend(pend), .mask(mask_q), .isr(isr_q), .nest(nest_q), .hit(sel_hit), .idx(sel_idx)
  );

  irq_stat_stack #(.DEPTH(STACK_DEPTH), .W(ENT_W)) u_stk (
    .clk(clk), .rst(rst), .push(ack_eff), .pop(pop_ok),
    .din({astat_in, mstat_in, mask_q}), .top_data(top_ent),
    .level(stack_level), .ovf(stack_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q        <= '0;
      edge_q        <= '0;
      nest_q        <= 1'b0;
      isr_q         <= '0;
      irq_valid     <= 1'b0;
      irq_vector    <= '0;
      irq_src       <= '0;
      restore_valid <= 1'b0;
      astat_restore <= '0;
      mstat_restore <= '0;
    end else begin
      restore_valid <= pop_ok;
      if (wr_en && wr_addr == WA_MASK) mask_q <= wr_data[NSRC-1:0];
      if (wr_en && wr_addr == WA_CTRL) begin
        edge_q <= wr_data[NPIN-1:0];
        nest_q <= wr_data[NEST_BIT];
      end
      if (pop_ok) begin
        mask_q        <= top_ent[NSRC-1:0];
        mstat_restore <= top_ent[NSRC +: MSTAT_W];
        astat_restore <= top_ent[NSRC + MSTAT_W +: ASTAT_W];
      end
      // return retires the most urgent handler in service
      if (rti)          isr_q <= isr_q & (isr_q - 1'b1);
      else if (ack_eff) isr_q <= isr_q | ack_clr;
      irq_valid <= sel_hit & ~ack_eff & ~rti;
      if (sel_hit) begin
        irq_src    <= sel_idx;
        irq_vector <= ADDR_W'(VEC_BASE + VEC_STEP * int'(sel_idx));
      end
    end
  end

  assign mask_out = mask_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int STACK_DEPTH = 7,
  parameter int VEC_BASE    = 4,
  parameter int VEC_STEP    = 4,
  localparam int SPW        = $clog2(STACK_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              ack,
  input logic              rti,
  input logic              irq_valid,
  input logic [ADDR_W-1:0] irq_vector,
  input logic [IDW-1:0]    irq_src,
  input logic [NSRC-1:0]   mask_out,
  input logic              restore_valid,
  input logic [SPW-1:0]    stack_level,
  input logic              stack_ovf
);
  logic [NSRC-1:0] mask_prev;
  always_ff @(posedge clk) mask_prev <= mask_out;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!irq_valid && stack_level == '0 && !stack_ovf && mask_out == '0));

  p_masked_never_r2: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> mask_prev[irq_src]);

  p_vector_map_r3: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (int'(irq_vector) == VEC_BASE + VEC_STEP * int'(irq_src)));

  p_push_count_r9: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_valid && !rti && stack_level < SPW'(STACK_DEPTH))
      |=> (stack_level == $past(stack_level) + 1'b1));

  p_restore_after_rti_r9: assert property (@(posedge clk) disable iff (rst)
    restore_valid |-> $past(rti));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    stack_ovf |=> stack_ovf);

  p_level_bound_r10: assert property (@(posedge clk) disable iff (rst)
    stack_level <= SPW'(STACK_DEPTH));

  p_empty_pop_r11: assert property (@(posedge clk) disable iff (rst)
    (rti && stack_level == '0) |=> !restore_valid);

  p_drop_after_ack_r12: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_valid && !rti) |=> !irq_valid);
endmodule

bind irq_ctrl_top irq_ctrl_chk #(
  .ADDR_W(ADDR_W), .STACK_DEPTH(STACK_DEPTH), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
  .clk(clk), .rst(rst), .ack(ack), .rti(rti), .irq_valid(irq_valid),
  .irq_vector(irq_vector), .irq_src(irq_src), .mask_out(mask_out),
  .restore_valid(restore_valid), .stack_level(stack_level), .stack_ovf(stack_ovf)
);

// File: tb/irq_ctrl_top_bench.sv
module irq_ctrl_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  ext_irq = '0;
  logic        tmr_evt = 0, sp0_tx_evt = 0, sp0_rx_evt = 0, sp1_tx_evt = 0, sp1_rx_evt = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  astat_in = '0, mstat_in = '0;
  logic        ack = 0, rti = 0;
  logic        irq_valid, restore_valid, stack_ovf;
  logic [13:0] irq_vector;
  logic [2:0]  irq_src, stack_level;
  logic [5:0]  mask_out;
  logic [7:0]  astat_restore, mstat_restore;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl_top #(.STACK_DEPTH(DEPTH)) u_irq_ctrl_top (
    .clk(clk), .rst(rst), .ext_irq(ext_irq), .tmr_evt(tmr_evt),
    .sp0_tx_evt(sp0_tx_evt), .sp0_rx_evt(sp0_rx_evt),
    .sp1_tx_evt(sp1_tx_evt), .sp1_rx_evt(sp1_rx_evt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .astat_in(astat_in), .mstat_in(mstat_in), .ack(ack), .rti(rti),
    .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_src(irq_src),
    .mask_out(mask_out), .astat_restore(astat_restore), .mstat_restore(mstat_restore),
    .restore_valid(restore_valid), .stack_level(stack_level), .stack_ovf(stack_ovf)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected offer: valid flag and source; vector computed as 4 + 4*src
  task automatic chk_offer(input string req, input bit ev, input int es);
    bit ok;
    ok = (irq_valid == ev) && (!ev || (int'(irq_src) == es && int'(irq_vector) == 4 + 4*es));
    chk(ok, req, {irq_valid, 4'h0, irq_vector}, {ev, 4'h0, 14'(ev ? 4 + 4*es : 0)});
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic do_ack(input logic [7:0] a, input logic [7:0] m);
    astat_in = a; mstat_in = m; ack = 1;
    tick();
    ack = 0;
  endtask

  task automatic do_rti();
    rti = 1;
    tick();
    rti = 0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tick(); tick(); tick();
    // R1: reset state
    chk(!irq_valid && mask_out == 0 && stack_level == 0 && !stack_ovf, "R1 reset",
        {irq_valid, mask_out, stack_level, stack_ovf}, 0);
    rst = 0;
    tick();
    chk(!irq_valid && mask_out == 0, "R1 after release", {irq_valid, mask_out}, 0);

    // R11: ack with nothing offered, rti on empty stack
    do_ack(8'h55, 8'h66);
    chk(stack_level == 0, "R11 stray ack", stack_level, 0);
    do_rti();
    chk(!restore_valid && stack_level == 0, "R11 empty pop", {restore_valid, stack_level}, 0);

    // R3/R2: sweep of forced request sets under several masks
    begin
      int masks [4] = '{6'h3F, 6'h15, 6'h2A, 6'h00};
      for (int mi = 0; mi < 4; mi++) begin
        wr(2'd0, 16'(masks[mi]));
        for (int s = 0; s < 64; s++) begin
          int el, es;
          el = s & masks[mi];
          es = 0;
          for (int b = 5; b >= 0; b--) if (el[b]) es = b;
          wr(2'd2, 16'(s));
          tick();
          chk_offer(el != 0 ? "R3 sweep priority" : "R2 sweep masked", el != 0, es);
          wr(2'd2, 16'h3F00);
          tick();
        end
      end
    end
    wr(2'd0, 16'h003F);

    // R8: clear wins over force on the same source
    wr(2'd2, 16'h0202);
    tick();
    chk_offer("R8 clear beats force", 0, 0);
    wr(2'd2, 16'h0002);
    tick();
    chk_offer("R8 force sets", 1, 1);
    wr(2'd2, 16'h0200);
    tick();
    chk_offer("R8 clear removes", 0, 0);

    // R3: internal event pulses are latched
    tmr_evt = 1; tick(); tmr_evt = 0;
    chk_offer("R12 latched not yet", 0, 0);
    tick();
    chk_offer("R3 timer event", 1, 5);
    sp0_rx_evt = 1; sp1_tx_evt = 1; tick(); sp0_rx_evt = 0; sp1_tx_evt = 0;
    tick();
    chk_offer("R3 port0 rx over port1 tx and timer", 1, 2);
    wr(2'd2, 16'h3F00); tick();
    chk_offer("R8 cleanup", 0, 0);

    // R5: level mode follows the pin
    wr(2'd1, 16'h0000);
    ext_irq[1] = 1; tick();
    chk_offer("R5 level pin1 offered", 1, 3);
    ext_irq[1] = 0; tick();
    chk_offer("R5 level withdrawn", 0, 0);

    // R2: masked level request, then unmask
    wr(2'd0, 16'h0000);
    ext_irq[0] = 1; tick(); tick();
    chk_offer("R2 masked not offered", 0, 0);
    wr(2'd0, 16'h0010);
    chk_offer("R12 mask write not yet seen", 0, 0);
    tick();
    chk_offer("R2 unmasked offered", 1, 4);
    ext_irq[0] = 0; tick();
    chk_offer("R5 pin0 dropped", 0, 0);
    wr(2'd0, 16'h003F);

    // R4: edge mode on pin 2
    wr(2'd1, 16'h0004);
    ext_irq[2] = 1; tick();
    chk_offer("R12 edge latched not yet", 0, 0);
    ext_irq[2] = 0; tick();
    chk_offer("R4 edge offered", 1, 0);
    tick();
    chk_offer("R4 held after pin fell", 1, 0);
    do_ack(8'h12, 8'h34);
    chk_offer("R12 drop after ack", 0, 0);
    chk(stack_level == 1, "R9 push level", stack_level, 1);
    do_rti();
    chk(restore_valid && astat_restore == 8'h12 && mstat_restore == 8'h34 && stack_level == 0,
        "R9 restore", {restore_valid, astat_restore, mstat_restore}, {1'b1, 16'h1234});
    tick();
    chk_offer("R4 latch cleared by ack", 0, 0);
    chk(!restore_valid, "R9 restore one cycle", restore_valid, 0);

    // R7: sequential mode
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h0008); tick();
    chk_offer("R7 first offered", 1, 3);
    do_ack(8'h01, 8'h02);
    wr(2'd2, 16'h0001); tick();
    chk_offer("R7 blocked while in service", 0, 0);
    do_rti();
    chk_offer("R7 still blocked on return edge", 0, 0);
    tick();
    chk_offer("R7 offered after return", 1, 0);
    do_ack(8'h03, 8'h04);
    do_rti();

    // R6: nested mode
    wr(2'd1, 16'h0010);
    ext_irq[0] = 1; tick();
    chk_offer("R6 base request", 1, 4);
    do_ack(8'h11, 8'h21);
    wr(2'd2, 16'h0020); tick(); tick();
    chk_offer("R6 less urgent waits", 0, 0);
    wr(2'd0, 16'h0003);
    ext_irq[2] = 1; tick();
    chk_offer("R6 more urgent preempts", 1, 0);
    do_ack(8'h22, 8'h42);
    chk(stack_level == 2, "R9 nested level", stack_level, 2);
    ext_irq = '0;
    do_rti();
    chk(restore_valid && astat_restore == 8'h22 && mstat_restore == 8'h42 && mask_out == 6'h03,
        "R9 inner restore", {astat_restore, mstat_restore, 2'b0, mask_out}, {16'h2242, 8'h03});
    do_rti();
    chk(astat_restore == 8'h11 && mstat_restore == 8'h21 && mask_out == 6'h3F && stack_level == 0,
        "R9 outer restore mask", {astat_restore, mstat_restore, 2'b0, mask_out}, {16'h1121, 8'h3F});
    tick();
    chk_offer("R6 waiting timer offered after returns", 1, 5);
    wr(2'd2, 16'h3F00); tick();

    // R10: overflow with a 4-deep stack
    for (int k = 5; k >= 1; k--) begin
      wr(2'd2, 16'(1 << k)); tick();
      chk_offer("R6 nested ladder", 1, k);
      do_ack(8'(8'h40 + k), 8'(8'h80 + k));
      if (k == 2) chk(!stack_ovf && stack_level == 4, "R10 full no overflow",
                      {stack_ovf, stack_level}, 4);
    end
    chk(stack_ovf && stack_level == 4, "R10 overflow sticky set", {stack_ovf, stack_level}, 12);
    for (int k = 2; k <= 5; k++) begin
      do_rti();
      chk(restore_valid && astat_restore == 8'(8'h40 + k) && mstat_restore == 8'(8'h80 + k),
          "R10 contents kept", {astat_restore, mstat_restore}, {8'(8'h40 + k), 8'(8'h80 + k)});
    end
    do_rti();
    chk(!restore_valid && stack_level == 0, "R11 pop past empty", {restore_valid, stack_level}, 0);
    chk(stack_ovf, "R10 overflow stays set", stack_ovf, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule